// File: doc/BRIEF.md
# Dual Accumulator Shift and Subtract Unit

This unit keeps a pair of 40-bit signed accumulators, called A and B. Each cycle it can apply one operation in place to the accumulator picked by a select input. It can load a value, shift arithmetically by a signed 5-bit amount, or subtract the other accumulator from the selected one. The shift amount comes either from a literal input or from the low five bits of a 16-bit register value. A negative amount shifts left and a positive amount shifts right.

Each accumulator carries two status bits that only report and never alter the data:

- The overflow bit shows that the latest shift or subtract produced a value that no longer fits in 32 signed bits.
- The saturation bit records, until it is cleared, that some result fell outside the signed 40-bit range.

No saturating arithmetic is performed.

Top module: `dual_acc_unit`

## Requirements
- R1: After reset both accumulators read zero and all four status bits read zero.
- R2: With op_i = 1 (load), the accumulator chosen by sel_i (0 = A, 1 = B) takes load_data_i on the next edge. The status bits of that accumulator are left unchanged.
- R3: With op_i = 2, the selected accumulator is shifted by shamt_i, read as a two's-complement amount from -16 to +15. A negative amount shifts left by its magnitude and a positive amount shifts right; an amount of zero leaves the value unchanged.
- R4: With op_i = 3, the shift amount is bits 4:0 of shreg_i read as in R3, and bits 15:5 have no effect.
- R5: A right shift fills from the top with copies of bit 39. A left shift fills bit 0 and upward with zeros. Bits moved past either end of the 40-bit value are lost.
- R6: With op_i = 4 and sel_i = 0, A becomes A minus B. With sel_i = 1, B becomes B minus A. Both are 40-bit two's-complement results, taken modulo 2^40.
- R7: Every shift and every subtract sets the overflow bit of the selected accumulator when bits 39:31 of the new value are not all equal, and clears it otherwise.
- R8: The saturation bit of the selected accumulator is set when the exact result of a shift or subtract lies outside -2^39 .. 2^39-1. It then stays set until sat_clr_i is high at an edge, which clears both saturation bits. If an out-of-range result occurs in the same cycle as the clear, the bit is set again.
- R9: The accumulator that is not selected and its overflow bit hold their values. op_i = 0 and the unused codes 5 to 7 change no accumulator and no overflow bit.
- R10: Every operation completes in one cycle: its result is on the outputs after the first rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation: 0 none, 1 load, 2 shift by literal, 3 shift by register, 4 subtract |
| sel_i | input | 1 | Target accumulator: 0 = A, 1 = B |
| shamt_i | input | 5 | Signed literal shift amount |
| shreg_i | input | 16 | Register value; only bits 4:0 give the shift amount |
| load_data_i | input | 40 | Value written by a load |
| sat_clr_i | input | 1 | Clears both saturation bits |
| acc_a_o | output | 40 | Accumulator A |
| acc_b_o | output | 40 | Accumulator B |
| ovf_a_o | output | 1 | A no longer fits in 32 signed bits |
| ovf_b_o | output | 1 | B no longer fits in 32 signed bits |
| sat_a_o | output | 1 | Sticky: an A result exceeded the 40-bit range |
| sat_b_o | output | 1 | Sticky: a B result exceeded the 40-bit range |

## Verification
Every result sits one register away from its inputs. The accumulators, the overflow bits and the saturation bits are all due immediately after the single rising edge that samples the operation.

The bench therefore drives each operation on a falling edge and compares all six outputs on the next falling edge, half a period after the capturing edge. It then returns op_i to idle, so the following edge also shows that nothing moves.

The bench sweeps every shift amount over a set of boundary values and both selects. It also crosses those values pairwise for the subtract. Expected values come from 64-bit arithmetic in the bench.

// File: rtl/dual_acc_pkg.sv
package dual_acc_pkg;
  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_LOAD      = 3'd1,
    OP_SHIFT_IMM = 3'd2,
    OP_SHIFT_REG = 3'd3,
    OP_SUB       = 3'd4
  } op_e;

  localparam int unsigned NUM_ACC = 2;
endpackage

// File: rtl/acc_shifter.sv
module acc_shifter #(
  parameter int unsigned W    = 40,
  parameter int unsigned SH_W = 5
) (
  input  logic [W-1:0]    val_i,
  input  logic [SH_W-1:0] amt_i,
  output logic [W-1:0]    res_o,
  output logic            wide_ovf_o
);
  logic            to_left;
  logic [SH_W-1:0] mag;
  logic [W-1:0]    left_res;
  logic [W-1:0]    right_res;

  assign to_left = amt_i[SH_W-1];
  // magnitude of the most negative amount still fits as unsigned
  assign mag = to_left ? (~amt_i + 1'b1) : amt_i;

  assign left_res  = val_i << mag;
  assign right_res = $signed(val_i) >>> mag;

  always_comb begin
    if (to_left) begin
      res_o      = left_res;
      wide_ovf_o = ($signed(left_res) >>> mag) != $signed(val_i);
    end else begin
      res_o      = right_res;
      wide_ovf_o = 1'b0;
    end
  end
endmodule

// File: rtl/acc_subtractor.sv
module acc_subtractor #(
  parameter int unsigned W = 40
) (
  input  logic [W-1:0] min_i,
  input  logic [W-1:0] sub_i,
  output logic [W-1:0] diff_o,
  output logic         wide_ovf_o
);
  assign diff_o     = min_i - sub_i;
  assign wide_ovf_o = (min_i[W-1] != sub_i[W-1]) && (diff_o[W-1] != min_i[W-1]);
endmodule

// File: rtl/acc_lane.sv
module acc_lane #(
  parameter int unsigned W  = 40,
  parameter int unsigned NW = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         flag_upd_i,
  input  logic         wide_ovf_i,
  input  logic         sat_clr_i,
  output logic [W-1:0] acc_o,
  output logic         ovf_o,
  output logic         sat_o
);
  localparam int unsigned TOP_W = W - NW + 1;

  logic [TOP_W-1:0] top_bits;
  logic             narrow_ovf;

  assign top_bits   = wr_data_i[W-1:NW-1];
  assign narrow_ovf = !((&top_bits) || !(|top_bits));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= '0;
      ovf_o <= 1'b0;
      sat_o <= 1'b0;
    end else begin
      if (wr_en_i) acc_o <= wr_data_i;
      if (wr_en_i && flag_upd_i) ovf_o <= narrow_ovf;
      sat_o <= (sat_o && !sat_clr_i) || (wr_en_i && flag_upd_i && wide_ovf_i);
    end
  end
endmodule

// File: rtl/dual_acc_unit.sv
module dual_acc_unit
  import dual_acc_pkg::*;
#(
  parameter int unsigned ACC_W    = 40,
  parameter int unsigned NARROW_W = 32,
  parameter int unsigned SH_W     = 5,
  parameter int unsigned REG_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       op_i,
  input  logic             sel_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic [REG_W-1:0] shreg_i,
  input  logic [ACC_W-1:0] load_data_i,
  input  logic             sat_clr_i,
  output logic [ACC_W-1:0] acc_a_o,
  output logic [ACC_W-1:0] acc_b_o,
  output logic             ovf_a_o,
  output logic             ovf_b_o,
  output logic             sat_a_o,
  output logic             sat_b_o
);
  logic [ACC_W-1:0] acc_q [NUM_ACC];
  logic             ovf_q [NUM_ACC];
  logic             sat_q [NUM_ACC];

  logic [ACC_W-1:0] own_val, other_val;
  logic [SH_W-1:0]  amt;
  logic [ACC_W-1:0] sh_res, sub_res, wr_data;
  logic             sh_ovf, sub_ovf, wide_ovf;
  logic             wr_any, flag_upd;
  logic             shreg_unused;

  assign shreg_unused = ^shreg_i[REG_W-1:SH_W];

  assign own_val   = sel_i ? acc_q[1] : acc_q[0];
  assign other_val = sel_i ? acc_q[0] : acc_q[1];
  assign amt       = (op_e'(op_i) == OP_SHIFT_REG) ? shreg_i[SH_W-1:0] : shamt_i;

  acc_shifter #(.W(ACC_W), .SH_W(SH_W)) u_shift (
    .val_i      (own_val),
    .amt_i      (amt),
    .res_o      (sh_res),
    .wide_ovf_o (sh_ovf)
  );

  acc_subtractor #(.W(ACC_W)) u_sub (
    .min_i      (own_val),
    .sub_i      (other_val),
    .diff_o     (sub_res),
    .wide_ovf_o (sub_ovf)
  );

  always_comb begin
    wr_any   = 1'b0;
    flag_upd = 1'b0;
    wr_data  = load_data_i;
    wide_ovf = 1'b0;
    case (op_e'(op_i))
      OP_LOAD: begin
        wr_any = 1'b1;
      end
      OP_SHIFT_IMM, OP_SHIFT_REG: begin
        wr_any   = 1'b1;
        flag_upd = 1'b1;
        wr_data  = sh_res;
        wide_ovf = sh_ovf;
      end
      OP_SUB: begin
        wr_any   = 1'b1;
        flag_upd = 1'b1;
        wr_data  = sub_res;
        wide_ovf = sub_ovf;
      end
      default: ;
    endcase
  end

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_lane
    acc_lane #(.W(ACC_W), .NW(NARROW_W)) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (wr_any && (sel_i == i[0])),
      .wr_data_i  (wr_data),
      .flag_upd_i (flag_upd),
      .wide_ovf_i (wide_ovf),
      .sat_clr_i  (sat_clr_i),
      .acc_o      (acc_q[i]),
      .ovf_o      (ovf_q[i]),
      .sat_o      (sat_q[i])
    );
  end

  assign acc_a_o = acc_q[0];
  assign acc_b_o = acc_q[1];
  assign ovf_a_o = ovf_q[0];
  assign ovf_b_o = ovf_q[1];
  assign sat_a_o = sat_q[0];
  assign sat_b_o = sat_q[1];
endmodule

// File: rtl/dual_acc_unit_chk.sv
module dual_acc_unit_chk #(
  parameter int unsigned ACC_W    = 40,
  parameter int unsigned NARROW_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       op_i,
  input logic             sel_i,
  input logic [ACC_W-1:0] load_data_i,
  input logic             sat_clr_i,
  input logic [ACC_W-1:0] acc_a_o,
  input logic [ACC_W-1:0] acc_b_o,
  input logic             ovf_a_o,
  input logic             ovf_b_o,
  input logic             sat_a_o,
  input logic             sat_b_o
);
  logic is_upd;
  assign is_upd = (op_i == 3'd2) || (op_i == 3'd3) || (op_i == 3'd4);

  AST_LOAD_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd1 && !sel_i) |=> acc_a_o == $past(load_data_i)); // R2

  AST_SUB_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && !sel_i) |=> acc_a_o == $past(acc_a_o) - $past(acc_b_o)); // R6

  AST_SUB_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd4 && sel_i) |=> acc_b_o == $past(acc_b_o) - $past(acc_a_o)); // R6

  AST_OVF_TRACKS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_upd && !sel_i) |=> ovf_a_o == !((&acc_a_o[ACC_W-1:NARROW_W-1]) || !(|acc_a_o[ACC_W-1:NARROW_W-1]))); // R7

  AST_SAT_STICKY_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_a_o && !sat_clr_i) |=> sat_a_o); // R8

  AST_SAT_STICKY_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_b_o && !sat_clr_i) |=> sat_b_o); // R8

  AST_OTHER_HOLDS_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i) |=> $stable(acc_b_o) && $stable(ovf_b_o)); // R9

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0) |=> $stable(acc_a_o) && $stable(acc_b_o)); // R9
endmodule

bind dual_acc_unit dual_acc_unit_chk #(.ACC_W(ACC_W), .NARROW_W(NARROW_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .op_i        (op_i),
  .sel_i       (sel_i),
  .load_data_i (load_data_i),
  .sat_clr_i   (sat_clr_i),
  .acc_a_o     (acc_a_o),
  .acc_b_o     (acc_b_o),
  .ovf_a_o     (ovf_a_o),
  .ovf_b_o     (ovf_b_o),
  .sat_a_o     (sat_a_o),
  .sat_b_o     (sat_b_o)
);

// File: tb/dual_acc_unit_bench.sv
module dual_acc_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        sel = 1'b0;
  logic [4:0]  lit = 5'd0;
  logic [15:0] rv = 16'd0;
  logic [39:0] ld = 40'd0;
  logic        clr = 1'b0;
  logic [39:0] acc_a, acc_b;
  logic        ovf_a, ovf_b, sat_a, sat_b;

  int total = 0;
  int bad = 0;

  longint m_acc [2];
  bit     m_ovf [2];
  bit     m_sat [2];

  always #2.5 clk = ~clk;

  dual_acc_unit u_dual_acc_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .sel_i(sel), .shamt_i(lit),
    .shreg_i(rv), .load_data_i(ld), .sat_clr_i(clr),
    .acc_a_o(acc_a), .acc_b_o(acc_b), .ovf_a_o(ovf_a), .ovf_b_o(ovf_b),
    .sat_a_o(sat_a), .sat_b_o(sat_b)
  );

  function automatic longint sx40(input logic [39:0] v);
    return longint'($signed(v));
  endfunction

  function automatic bit narrow_ovf(input longint r);
    return (r < -64'sd2147483648) || (r > 64'sd2147483647);
  endfunction

  function automatic logic [39:0] pick(input int i);
    case (i)
      0: return 40'h00_0000_1234;
      1: return 40'h7F_FFFF_FFFF;
      2: return 40'h80_0000_0000;
      3: return 40'hFF_FFFF_FFFF;
      4: return 40'h00_8000_0000;
      5: return 40'hFF_7FFF_FFFF;
      6: return 40'h12_3456_789A;
      default: return 40'h00_0000_0001;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag, input bit s);
    logic [39:0] ea, eb;
    ea = m_acc[0][39:0];
    eb = m_acc[1][39:0];
    check(s ? "R9" : tag, "acc_a", {24'd0, acc_a}, {24'd0, ea});
    check(s ? tag : "R9", "acc_b", {24'd0, acc_b}, {24'd0, eb});
    check(s ? "R9" : "R7", "ovf_a", {63'd0, ovf_a}, {63'd0, m_ovf[0]});
    check(s ? "R7" : "R9", "ovf_b", {63'd0, ovf_b}, {63'd0, m_ovf[1]});
    check("R8", "sat_a", {63'd0, sat_a}, {63'd0, m_sat[0]});
    check("R8", "sat_b", {63'd0, sat_b}, {63'd0, m_sat[1]});
  endtask

  // drive on a falling edge, compare one falling edge later (R10)
  task automatic step(input logic [2:0] o, input bit s, input logic [4:0] l,
                      input logic [15:0] r, input logic [39:0] d, input bit c, input string tag);
    longint own, full, res;
    int amt;
    bit upd, wide;
    op = o; sel = s; lit = l; rv = r; ld = d; clr = c;
    own = m_acc[s];
    upd = 1'b0; wide = 1'b0; res = own;
    case (o)
      3'd1: res = sx40(d);
      3'd2, 3'd3: begin
        amt = (o == 3'd3) ? int'($signed(r[4:0])) : int'($signed(l));
        upd = 1'b1;
        if (amt < 0) begin
          full = own <<< (-amt);
          res  = sx40(full[39:0]);
          wide = (full != res);
        end else begin
          res = own >>> amt;
        end
      end
      3'd4: begin
        full = own - m_acc[!s];
        res  = sx40(full[39:0]);
        wide = (full != res);
        upd  = 1'b1;
      end
      default: ;
    endcase
    if (c) begin m_sat[0] = 1'b0; m_sat[1] = 1'b0; end
    if (o inside {3'd1, 3'd2, 3'd3, 3'd4}) m_acc[s] = res;
    if (upd) begin
      m_ovf[s] = narrow_ovf(res);
      if (wide) m_sat[s] = 1'b1;
    end
    @(negedge clk);
    check_all(tag, s);
    op = 3'd0; clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_acc[i] = 0; m_ovf[i] = 0; m_sat[i] = 0; end
    repeat (3) @(negedge clk);
    check_all("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 loads leave flags alone
    step(3'd1, 1'b0, 5'd0, 16'd0, 40'h7F_0000_0000, 1'b0, "R2");
    step(3'd1, 1'b1, 5'd0, 16'd0, 40'h00_0000_0005, 1'b0, "R2");
    step(3'd4, 1'b0, 5'd0, 16'd0, 40'd0, 1'b0, "R6");
    step(3'd1, 1'b0, 5'd0, 16'd0, 40'h00_0000_0001, 1'b0, "R2");

    // R3 R5 literal shift sweep on A, R4 register shift on B with junk upper bits
    for (int v = 0; v < 8; v++) begin
      for (int a = 0; a < 32; a++) begin
        step(3'd1, 1'b0, 5'd0, 16'd0, pick(v), 1'b0, "R2");
        step(3'd2, 1'b0, a[4:0], 16'hFFE0, 40'd0, 1'b0, (a == 0) ? "R3" : "R5");
        step(3'd1, 1'b1, 5'd0, 16'd0, pick(7 - v), 1'b0, "R2");
        step(3'd3, 1'b1, ~a[4:0], {a[10:0], a[4:0]}, 40'd0, 1'b0, "R4");
      end
      step(3'd0, 1'b0, 5'd0, 16'd0, 40'd0, 1'b1, "R8");
    end

    // R6 subtract cross both directions
    for (int x = 0; x < 8; x++) begin
      for (int y = 0; y < 8; y++) begin
        step(3'd1, 1'b0, 5'd0, 16'd0, pick(x), 1'b0, "R2");
        step(3'd1, 1'b1, 5'd0, 16'd0, pick(y), 1'b0, "R2");
        step(3'd4, y[0], 5'd0, 16'd0, 40'd0, 1'b0, "R6");
        step(3'd0, 1'b0, 5'd0, 16'd0, 40'd0, 1'b0, "R9");
      end
    end

    // R8 clear together with a fresh out-of-range result re-sets the bit
    step(3'd1, 1'b0, 5'd0, 16'd0, 40'h80_0000_0000, 1'b0, "R2");
    step(3'd1, 1'b1, 5'd0, 16'd0, 40'h00_0000_0001, 1'b0, "R2");
    step(3'd4, 1'b0, 5'd0, 16'd0, 40'd0, 1'b1, "R8");
    step(3'd0, 1'b0, 5'd0, 16'd0, 40'd0, 1'b1, "R8");

    // R9 unused codes change nothing
    for (int k = 5; k < 8; k++) step(k[2:0], k[0], 5'd1, 16'd1, 40'h1, 1'b0, "R9");

    // R10 a single edge suffices for a result
    step(3'd2, 1'b0, 5'd1, 16'd0, 40'd0, 1'b0, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule